// File: doc/BRIEF.md
# Data-Ready Triggered Converter Frame Reader

This block is an SPI master that pulls conversion frames out of a multichannel delta-sigma converter. It watches the converter's active-low data-ready line. That input is asynchronous, so it is first brought into the local clock domain. Each high-to-low transition of the line while the block is enabled and idle starts one frame read. Chip select stays low for the whole read. Six words are clocked in: a status word, four channel words and a CRC slot. The CRC slot is always clocked, so the frame length never changes. The serial output carries only zeros while the frame is read.

Every word received is presented for one cycle on a valid/data stream. The stream carries a word index and is always 32 bits wide. The serial clock rate and the word width (24 or 32 bits) are taken from inputs at the start of each frame. The converter holds two results in its output buffer. For that reason, the first frame after the block is enabled is clocked in full and then thrown away. A data-ready edge that arrives while a frame is running raises a one-cycle overrun flag and is otherwise dropped.

Top module: `adc_frame_reader`

## Requirements
- R1: When `enable` is high and no frame is running, a falling edge on `drdy_n` pulls `cs_n` low within 4 clock cycles. The input passes through a two-flop synchronizer first.
- R2: `cs_n` stays low for the whole frame. A frame is 6 words, and `sclk` rises exactly 6×W times in one frame, where W is the word width.
- R3: The SPI runs in mode 1. `sclk` is low whenever `cs_n` is high. Each high phase and each low phase of `sclk` lasts `clk_div`+1 clock cycles. `miso` is sampled on the falling edge of `sclk`, MSB first.
- R4: `mosi` is 0 at all times.
- R5: `wide_words` is sampled at frame start. A value of 1 selects 32-bit words, which are output as received. A value of 0 selects 24-bit words, which are sign-extended from bit 23 onto the 32-bit `word_data`.
- R6: Each word is output with `word_valid` high for exactly one cycle. `word_idx` goes from 0 (status) through 1–4 (channels) to 5 (CRC slot), in that order.
- R7: The first frame after `enable` rises is fully clocked but produces no `word_valid`. Dropping `enable` re-arms this discard.
- R8: A falling edge on `drdy_n` during a running frame gives a one-cycle `overrun` pulse. It does not start another frame.
- R9: While `enable` is low, `drdy_n` edges start no frame.
- R10: During and right after reset, `cs_n` is 1 and `sclk`, `word_valid` and `overrun` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Allows frame reads; a low level re-arms the first-frame discard |
| clk_div | input | DIV_W | Length of each SCLK half-period, minus one, in clock cycles |
| wide_words | input | 1 | 1 = 32-bit words, 0 = 24-bit words |
| drdy_n | input | 1 | Asynchronous active-low data-ready from the converter |
| miso | input | 1 | Serial data from the converter |
| sclk | output | 1 | Serial clock, idles low |
| cs_n | output | 1 | Active-low chip select |
| mosi | output | 1 | Serial data to the converter, always zero |
| word_valid | output | 1 | One-cycle strobe marking a received word |
| word_data | output | 32 | Received word, right-justified and sign-extended |
| word_idx | output | 3 | Position of the word within its frame |
| overrun | output | 1 | One-cycle flag for a data-ready edge seen mid-frame |

## Verification
The hardest case to reach from the ports is a second data-ready edge inside a running frame. It must be counted as an overrun without disturbing the words in flight or starting an extra frame. The bench gets there by releasing data-ready once chip select has fallen and pulsing it low again a few dozen cycles into the serial transfer. It then checks that the frame's six words still match the slave model and that only one frame was started. The first-frame discard is reached twice: once at start-up and once after a disable/enable cycle. An edge during the disabled window checks that nothing is started.

// File: rtl/adc_frame_reader.sv
module adc_frame_reader #(
  parameter int DIV_W = 8,
  parameter int NW    = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [DIV_W-1:0] clk_div,
  input  logic             wide_words,
  input  logic             drdy_n,
  input  logic             miso,
  output logic             sclk,
  output logic             cs_n,
  output logic             mosi,
  output logic             word_valid,
  output logic [31:0]      word_data,
  output logic [2:0]       word_idx,
  output logic             overrun
);
  localparam int CW = $clog2(NW + 1);

  logic             s1, s2, s3;
  logic             busy, primed, drop, wide;
  logic [DIV_W-1:0] div_l, cnt;
  logic [5:0]       bcnt;
  logic [CW-1:0]    wcnt;
  logic [31:0]      sh;

  wire        fall  = s3 & ~s2;
  wire [5:0]  wlast = wide ? 6'd31 : 6'd23;
  wire [31:0] full  = {sh[30:0], miso};
  wire [31:0] ext   = wide ? full : {{8{full[23]}}, full[23:0]};

  assign cs_n = ~busy;
  assign mosi = 1'b0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b1; s2 <= 1'b1; s3 <= 1'b1;
      busy <= 1'b0; primed <= 1'b0; drop <= 1'b0; wide <= 1'b0;
      div_l <= '0; cnt <= '0; bcnt <= '0; wcnt <= '0; sh <= '0;
      sclk <= 1'b0; word_valid <= 1'b0; word_data <= '0; word_idx <= '0;
      overrun <= 1'b0;
    end else begin
      s1 <= drdy_n; s2 <= s1; s3 <= s2;
      word_valid <= 1'b0;
      overrun    <= 1'b0;
      if (!enable) primed <= 1'b0;
      if (!busy) begin
        sclk <= 1'b0;
        if (enable && fall) begin
          busy  <= 1'b1;
          drop  <= ~primed;
          wide  <= wide_words;
          div_l <= clk_div;
          cnt   <= clk_div;
          bcnt  <= '0;
          wcnt  <= '0;
        end
      end else begin
        if (fall) overrun <= 1'b1;
        if (cnt != '0) begin
          cnt <= cnt - 1'b1;
        end else begin
          cnt <= div_l;
          if (sclk) begin
            sclk <= 1'b0;
            sh   <= full;
            if (bcnt == wlast) begin
              bcnt       <= '0;
              wcnt       <= wcnt + 1'b1;
              word_valid <= ~drop;
              word_idx   <= 3'(wcnt);
              word_data  <= ext;
            end else begin
              bcnt <= bcnt + 1'b1;
            end
          end else if (wcnt == CW'(NW)) begin
            busy <= 1'b0;
            if (enable) primed <= 1'b1;
          end else begin
            sclk <= 1'b1;
          end
        end
      end
    end
  end

  a_r1_start_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> $past(enable));
  a_r2_cs_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && wcnt < CW'(NW)) |=> !cs_n);
  a_r3_sclk_idle: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sclk);
  a_r6_idx_range: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |-> word_idx < 3'(NW));
  a_r6_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |=> !word_valid);
  a_r8_overrun_busy: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |-> $past(!cs_n));
endmodule

// File: tb/adc_frame_reader_bench.sv
module adc_frame_reader_bench;
  logic clk = 0, rst_n = 0, enable = 0, wide_words = 1, drdy_n = 1, miso = 0;
  logic [7:0] clk_div = 1;
  logic sclk, cs_n, mosi, word_valid, overrun;
  logic [31:0] word_data;
  logic [2:0] word_idx;

  adc_frame_reader u_adc_frame_reader (.clk, .rst_n, .enable, .clk_div, .wide_words,
    .drdy_n, .miso, .sclk, .cs_n, .mosi, .word_valid, .word_data, .word_idx, .overrun);

  always #2 clk = ~clk;

  int checks = 0, fails = 0;
  logic [31:0] tw [6];
  int sw = 0, sb = 0, wb = 32;
  int rises = 0, frames = 0, overruns = 0, valids = 0, hirun = 0, cur_div = 1;
  logic [31:0] exp_d [$];
  int exp_i [$];
  bit primed_m = 0, done = 0;

  task automatic chk(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge cs_n) if (rst_n) begin sw = 0; sb = 0; rises = 0; frames++; end
  always @(posedge sclk) if (!cs_n) begin
    rises++;
    if (sw < 6) miso <= tw[sw][wb-1-sb];
    sb++;
    if (sb == wb) begin sb = 0; sw++; end
  end
  always @(posedge cs_n) if (rst_n && frames > 0)
    chk(rises == 6 * wb, "R2 sclk rises per frame", rises, 6 * wb);

  always @(negedge clk) if (rst_n && !done) begin
    chk(mosi == 1'b0, "R4 mosi", mosi, 0);
    if (cs_n) chk(sclk == 1'b0, "R3 sclk idle", sclk, 0);
    if (sclk) hirun++;
    else if (hirun != 0) begin
      chk(hirun == cur_div + 1, "R3 sclk half period", hirun, cur_div + 1);
      hirun = 0;
    end
    if (overrun) overruns++;
    if (word_valid) begin
      valids++;
      if (exp_d.size() == 0) chk(0, "R7 unexpected word", word_data, 0);
      else begin
        logic [31:0] d; int ix;
        d = exp_d.pop_front(); ix = exp_i.pop_front();
        chk(word_data == d, "R5 word data", word_data, d);
        chk(int'(word_idx) == ix, "R6 word index", word_idx, ix);
      end
    end
  end

  task automatic run_frame(bit w, int div, bit pulse_overrun, int seed);
    int lat; int f0; int o0;
    wide_words = w; clk_div = 8'(div); wb = w ? 32 : 24; cur_div = div;
    for (int k = 0; k < 6; k++) begin
      tw[k] = 32'h9E37_79B9 * (seed + k) ^ (32'h00A5_5A00 << k);
      if (primed_m) begin
        exp_d.push_back(w ? tw[k] : {{8{tw[k][23]}}, tw[k][23:0]});
        exp_i.push_back(k);
      end
    end
    f0 = frames; o0 = overruns;
    @(negedge clk) drdy_n = 0;
    lat = 0;
    for (int k = 1; k <= 8; k++) begin
      @(negedge clk);
      if (!cs_n && lat == 0) lat = k;
    end
    chk(lat != 0 && lat <= 4, "R1 start latency", lat, 3);
    drdy_n = 1;
    if (pulse_overrun) begin
      repeat (30) @(negedge clk);
      drdy_n = 0; repeat (4) @(negedge clk); drdy_n = 1;
    end
    for (int k = 0; k < 20000 && !cs_n; k++) @(negedge clk);
    repeat (12) @(negedge clk);
    chk(frames == f0 + 1, "R8 one frame per start", frames, f0 + 1);
    chk(overruns == o0 + (pulse_overrun ? 1 : 0), "R8 overrun count", overruns - o0,
        pulse_overrun ? 1 : 0);
    chk(exp_d.size() == 0, "R6 all words delivered", exp_d.size(), 0);
    primed_m = 1;
  endtask

  initial begin
    #400000;
    chk(0, "watchdog", 0, 1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    chk(cs_n === 1'b1 && sclk === 1'b0, "R10 reset outputs", {cs_n, sclk}, 2'b10);
    chk(word_valid === 1'b0 && overrun === 1'b0, "R10 reset strobes", {word_valid, overrun}, 0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    enable = 1;
    run_frame(1, 1, 0, 1);
    chk(valids == 0, "R7 first frame discarded", valids, 0);
    run_frame(1, 1, 0, 7);
    run_frame(0, 0, 0, 13);
    run_frame(1, 3, 1, 21);
    run_frame(0, 2, 0, 40);
    enable = 0;
    begin
      int f0; f0 = frames;
      @(negedge clk) drdy_n = 0; repeat (20) @(negedge clk); drdy_n = 1;
      repeat (10) @(negedge clk);
      chk(frames == f0 && cs_n, "R9 disabled edge ignored", frames, f0);
    end
    enable = 1; primed_m = 0;
    begin
      int v0; v0 = valids;
      run_frame(0, 1, 0, 55);
      chk(valids == v0, "R7 discard after re-enable", valids - v0, 0);
    end
    run_frame(0, 2, 0, 77);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule